// File: doc/BRIEF.md
# Circular Pass-Window Phase Selector

This block chooses a sampling phase for a receive path once a sweep over all delay-line phases has been scored. The caller presents a 16-bit mask in which bit i is set when phase i sampled correctly, and pulses a start strobe. One clock later the block raises a done pulse together with the chosen phase and an error flag.

Passing phases are grouped into runs of neighbouring phases. The top phase and phase 0 count as neighbours, so a run ending at the top phase and a run beginning at phase 0 are joined into one window. The longest window is chosen. The selected phase is not the centre of that window but a point three quarters of the way into it. The result stays on the outputs until the next start. Gathering the pass results and programming the delay line are done by other logic.

Top module: `phase_window_sel`

## Requirements
- R1: Set bits of the mask are grouped in ascending phase order into windows. A new window begins wherever a set bit's lower neighbour is clear. The chosen phase is (window start + k) mod 16, where k comes from R5.
- R2: When bit 0 and bit 15 are both set and the mask is not all ones, the window that starts at phase 0 is joined onto the window that holds phase 15. The joined window takes the ordering slot of the phase-15 window.
- R3: In a joined window, the members of the phase-15 window come first and the members of the phase-0 window follow. For example, mask 0xE007 selects phase 0.
- R4: The window with the largest member count wins. On a tie, the window that comes earlier in the ordering wins. For example, 0x01CE selects phase 2 and 0xC1E3 selects phase 7.
- R5: With n members in the chosen window, k = floor(3n/4), reduced by 1 when that value is nonzero. For example, a single phase 5 selects 5, and 0x0F00 selects 10.
- R6: err_o is 1 exactly when the mask given at start is all zeros, and phase_o is 0 whenever err_o is 1. A joined window holds at most 15 phases, so the overflow error is never raised by a non-empty mask.
- R7: An all-ones mask forms one window without joining and selects phase 11.
- R8: done_o is 1 in the cycle after each cycle in which start_i is 1, and 0 otherwise.
- R9: phase_o and err_o change only in the cycle after a start. Changes on pass_mask_i while start_i is low have no effect on them.
- R10: After reset, done_o, phase_o and err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sample the mask and compute a new phase |
| pass_mask_i | input | 16 | Bit i set when phase i passed |
| done_o | output | 1 | One-cycle pulse: new result valid |
| phase_o | output | 4 | Selected phase, held until next start |
| err_o | output | 1 | Invalid mask (no passing phase) |

## Verification
A wrong run-length or head flag inside the block shows up as a wrong phase_o in the very cycle of done_o. It appears for the masks whose longest window contains that phase. A broken join shows only for masks with both end bits set. A broken tie rule shows only when two windows have equal length. For that reason all 65536 masks are swept, so every join and tie pattern is covered. A fault in the output registers shows one cycle later, as a result that does not hold, or a done_o pulse that lasts too long or never comes.

// File: rtl/ph_sel_pkg.sv
package ph_sel_pkg;
    localparam int DEF_NUM_PHASES = 16;

    // three-quarter position inside a window of n members
    function automatic int tq_index(input int n);
        int k;
        k = (n * 3) / 4;
        if (k != 0) k = k - 1;
        return k;
    endfunction
endpackage

// File: rtl/ph_run_len.sv
module ph_run_len #(
    parameter int NUM_PHASES = 16,
    parameter int LEN_W      = $clog2(NUM_PHASES + 1)
) (
    input  logic [NUM_PHASES-1:0]            mask_i,
    output logic [NUM_PHASES-1:0]            head_o,
    output logic [NUM_PHASES-1:0][LEN_W-1:0] len_o
);
    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_pos
        if (i == 0) begin : g_first
            assign head_o[i] = mask_i[i];
        end else begin : g_rest
            assign head_o[i] = mask_i[i] & ~mask_i[i-1];
        end

        always_comb begin
            logic alive;
            alive    = 1'b1;
            len_o[i] = '0;
            for (int j = i; j < NUM_PHASES; j++) begin
                alive = alive & mask_i[j];
                if (alive) len_o[i] = len_o[i] + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/ph_wrap_merge.sv
module ph_wrap_merge #(
    parameter int NUM_PHASES = 16,
    parameter int LEN_W      = $clog2(NUM_PHASES + 1),
    localparam int IDX_W     = $clog2(NUM_PHASES)
) (
    input  logic [NUM_PHASES-1:0]            mask_i,
    input  logic [NUM_PHASES-1:0]            head_i,
    input  logic [NUM_PHASES-1:0][LEN_W-1:0] len_i,
    output logic [NUM_PHASES-1:0][LEN_W-1:0] win_len_o,
    output logic                             ovf_o
);
    logic             wrap;
    logic [IDX_W-1:0] last_head;
    logic [LEN_W:0]   joined;

    assign wrap = mask_i[0] & mask_i[NUM_PHASES-1] & ~(&mask_i);

    always_comb begin
        last_head = '0;
        for (int i = 0; i < NUM_PHASES; i++) begin
            if (head_i[i]) last_head = IDX_W'(i);
        end
    end

    assign joined = {1'b0, len_i[last_head]} + {1'b0, len_i[0]};
    assign ovf_o  = wrap && (joined >= (LEN_W+1)'(NUM_PHASES));

    always_comb begin
        for (int i = 0; i < NUM_PHASES; i++) begin
            win_len_o[i] = head_i[i] ? len_i[i] : '0;
        end
        if (wrap) begin
            win_len_o[0]         = '0;
            win_len_o[last_head] = joined[LEN_W-1:0];
        end
    end
endmodule

// File: rtl/ph_pick.sv
module ph_pick #(
    parameter int NUM_PHASES = 16,
    parameter int LEN_W      = $clog2(NUM_PHASES + 1),
    localparam int IDX_W     = $clog2(NUM_PHASES)
) (
    input  logic [NUM_PHASES-1:0][LEN_W-1:0] win_len_i,
    output logic [IDX_W-1:0]                 best_start_o,
    output logic [LEN_W-1:0]                 best_len_o
);
    always_comb begin
        best_start_o = '0;
        best_len_o   = '0;
        for (int i = 0; i < NUM_PHASES; i++) begin
            if (win_len_i[i] > best_len_o) begin
                best_len_o   = win_len_i[i];
                best_start_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/phase_window_sel.sv
module phase_window_sel #(
    parameter int NUM_PHASES = ph_sel_pkg::DEF_NUM_PHASES,
    localparam int PH_W      = $clog2(NUM_PHASES),
    localparam int LEN_W     = $clog2(NUM_PHASES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [NUM_PHASES-1:0] pass_mask_i,
    output logic                  done_o,
    output logic [PH_W-1:0]       phase_o,
    output logic                  err_o
);
    typedef struct packed {
        logic            done;
        logic [PH_W-1:0] phase;
        logic            err;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [NUM_PHASES-1:0]            head;
    logic [NUM_PHASES-1:0][LEN_W-1:0] run_len;
    logic [NUM_PHASES-1:0][LEN_W-1:0] win_len;
    logic                             ovf;
    logic [PH_W-1:0]                  best_start;
    logic [LEN_W-1:0]                 best_len;
    logic [PH_W-1:0]                  pick_phase;

    ph_run_len #(.NUM_PHASES(NUM_PHASES), .LEN_W(LEN_W)) u_runs (
        .mask_i (pass_mask_i),
        .head_o (head),
        .len_o  (run_len)
    );

    ph_wrap_merge #(.NUM_PHASES(NUM_PHASES), .LEN_W(LEN_W)) u_merge (
        .mask_i    (pass_mask_i),
        .head_i    (head),
        .len_i     (run_len),
        .win_len_o (win_len),
        .ovf_o     (ovf)
    );

    ph_pick #(.NUM_PHASES(NUM_PHASES), .LEN_W(LEN_W)) u_pick (
        .win_len_i    (win_len),
        .best_start_o (best_start),
        .best_len_o   (best_len)
    );

    // start plus three-quarter offset, wrapping modulo NUM_PHASES
    always_comb begin
        int k;
        k          = ph_sel_pkg::tq_index(int'(best_len));
        pick_phase = PH_W'((int'(best_start) + k) % NUM_PHASES);
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        if (start_i) begin
            st_d.err   = (pass_mask_i == '0) || ovf;
            st_d.phase = st_d.err ? '0 : pick_phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o  = st_q.done;
    assign phase_o = st_q.phase;
    assign err_o   = st_q.err;
endmodule

// File: rtl/ph_sel_chk.sv
module ph_sel_chk #(
    parameter int NUM_PHASES = 16,
    localparam int PH_W      = $clog2(NUM_PHASES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic [NUM_PHASES-1:0] pass_mask_i,
    input logic                  done_o,
    input logic [PH_W-1:0]       phase_o,
    input logic                  err_o
);
    localparam logic [PH_W-1:0] FULL_PH = PH_W'(ph_sel_pkg::tq_index(NUM_PHASES));

    a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(phase_o) && $stable(err_o)));
    a_r6_err_iff_empty: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (err_o == ($past(pass_mask_i) == '0)));
    a_r6_err_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (phase_o == '0));
    a_r7_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (&pass_mask_i)) |=> (phase_o == FULL_PH && !err_o));
endmodule

bind phase_window_sel ph_sel_chk #(.NUM_PHASES(NUM_PHASES)) u_ph_sel_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pass_mask_i (pass_mask_i),
    .done_o      (done_o),
    .phase_o     (phase_o),
    .err_o       (err_o)
);

// File: tb/test_phase_window_sel.sv
`timescale 1ns/1ps
module test_phase_window_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] pass_mask_i = '0;
    logic        done_o;
    logic [3:0]  phase_o;
    logic        err_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    phase_window_sel i_phase_window_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pass_mask_i (pass_mask_i),
        .done_o      (done_o),
        .phase_o     (phase_o),
        .err_o       (err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model: list of windows, join ends, longest wins, 3/4 position
    task automatic ref_model(input logic [15:0] m, output int ph,
                             output bit err, output bit joined);
        int st[16];
        int ln[16];
        int nw, best, bl, k;
        nw = 0;
        joined = 1'b0;
        for (int p = 0; p < 16; p++) begin
            if (m[p]) begin
                if (p == 0 || !m[p-1]) begin
                    st[nw] = p; ln[nw] = 0; nw++;
                end
                ln[nw-1]++;
            end
        end
        err = (nw == 0);
        ph  = 0;
        if (!err) begin
            if (nw > 1 && st[0] == 0 && st[nw-1] + ln[nw-1] == 16) begin
                joined = 1'b1;
                ln[nw-1] += ln[0];
                ln[0] = 0;
            end
            best = 0; bl = 0;
            for (int w = 0; w < nw; w++) if (ln[w] > bl) begin bl = ln[w]; best = w; end
            k = (bl * 3) / 4;
            if (k != 0) k--;
            ph = (st[best] + k) % 16;
        end
    endtask

    task automatic run_one(input logic [15:0] m, input string tag, input int exp_ph);
        @(negedge clk);
        start_i = 1'b1; pass_mask_i = m;
        @(negedge clk);
        start_i = 1'b0; pass_mask_i = ~m;
        chk({tag, " done"}, int'(done_o), 1);
        chk({tag, " phase"}, int'(phase_o), exp_ph);
        @(negedge clk);
        chk("R8 done low", int'(done_o), 0);
        chk("R9 phase held", int'(phase_o), exp_ph);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int  eph, prev_ph;
        bit  eerr, ejn, prev_err;
        string tag;
        repeat (3) @(negedge clk);
        chk("R10 done", int'(done_o), 0);
        chk("R10 phase", int'(phase_o), 0);
        chk("R10 err", int'(err_o), 0);
        rst_n = 1'b1;

        run_one(16'h0020, "R5 single", 5);
        run_one(16'h0F00, "R5 four", 10);
        run_one(16'h01CE, "R4 tie", 2);
        run_one(16'hC1E3, "R4 tie joined", 7);
        run_one(16'hE007, "R3 join order", 0);
        run_one(16'hFFFF, "R7 full", 11);
        run_one(16'h0000, "R6 empty", 0);
        chk("R6 err", int'(err_o), 1);

        prev_ph = 0; prev_err = 1'b1;
        for (int m = 0; m < 65536; m++) begin
            @(negedge clk);
            chk("R8 no done", int'(done_o), 0);
            chk("R9 phase held", int'(phase_o), prev_ph);
            chk("R9 err held", int'(err_o), int'(prev_err));
            start_i = 1'b1; pass_mask_i = 16'(m);
            ref_model(16'(m), eph, eerr, ejn);
            if (m == 0) tag = "R6";
            else if (m == 65535) tag = "R7";
            else if (ejn) tag = "R2";
            else tag = "R1";
            @(negedge clk);
            start_i = 1'b0; pass_mask_i = ~16'(m);
            chk("R8 done", int'(done_o), 1);
            chk({tag, " phase"}, int'(phase_o), eph);
            chk("R6 err", int'(err_o), int'(eerr));
            prev_ph = eph; prev_err = eerr;
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule